// File: doc/BRIEF.md
# Chained-Descriptor DMA Transfer Unit Engine

This engine moves one transfer unit for whichever channel a scheduler has granted. When `start` is asserted, the engine copies the channel's working registers from its inputs. It then collects source items from memory until one destination-width item is complete, and writes that item out. It can step either address after each access, and it lowers the 12-bit count held in the low bits of the control word. When that count reaches zero, one of two things happens. If the link pointer is non-zero, the engine fetches the next descriptor from memory. If the link pointer is zero, it clears the channel enable. The updated registers are presented on the `out_*` ports, and the scheduler writes them back when `done` pulses.

Memory traffic goes through a single request channel with a valid/ready handshake. The engine is the initiator on this channel. It raises `mem_req_valid` and keeps the address, direction, write data and byte enables unchanged until the memory accepts them with `mem_req_ready`. Memory may hold `mem_req_ready` low for as long as it needs to apply back-pressure. Once a read has been accepted, the engine issues nothing new until `mem_rsp_valid` returns the word. Writes are complete when they are accepted and have no response. The data bus is 32 bits wide and addresses are byte addresses. Each item must be aligned to its own width.

Top module: `xfer_unit_engine`

## Requirements
- R1: While `mem_req_valid` is high and `mem_req_ready` is low, the engine keeps the request stable. The engine has at most one read in flight and makes no request between an accepted read and its `mem_rsp_valid`.
- R2: The source item size is 2^k bytes, where k is control bits 20:18. The destination item size is 2^k bytes, where k is control bits 23:21. Any code above 2 is treated as 2 (4 bytes).
- R3: A unit performs max(1, dst/src) source reads and max(1, src/dst) destination writes. The number of bytes written equals the larger of the two sizes, and the bytes keep their source order.
- R4: If control bit 26 is set, the source address advances by the source size after each read; otherwise it stays fixed. If control bit 27 is set, the destination address advances by the destination size after each write; otherwise it stays fixed.
- R5: After a unit, the count in control bits 11:0 is one lower than before, and bits 31:12 are unchanged.
- R6: A start with a count of zero makes no memory access, pulses `done` one cycle after the start, and leaves every register as loaded.
- R7: If the count reaches zero and the link pointer is non-zero, the engine reads four little-endian words in this order: pointer+0 into source, pointer+4 into destination, pointer+12 into control, and last pointer+8 into the link pointer. The enable stays set.
- R8: If the count reaches zero and the link pointer is zero, `out_en` is cleared.
- R9: `tc_evt` is high together with `done` only when the count reached zero and bit 31 of the control word of the unit that just finished was set. This holds even if a reloaded descriptor has bit 31 clear.
- R10: After reset, the engine is idle with all outputs zero. `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse. While busy, the engine ignores `start`, and while idle it makes no requests.
- R11: A write places its item on byte lanes starting at address bits 1:0 and sets exactly those lanes in `mem_req_be`. A read takes the item from the lanes at address bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one unit using the in_* values (ignored while busy) |
| in_src | input | 32 | Source address of the granted channel |
| in_dst | input | 32 | Destination address |
| in_link | input | 32 | Link pointer (zero means end of chain) |
| in_ctrl | input | 32 | Control word: count, sizes, increments, event request |
| in_en | input | 1 | Channel enable |
| busy | output | 1 | Unit in progress |
| done | output | 1 | One-cycle pulse at the end of a unit |
| tc_evt | output | 1 | Terminal-count event, valid with done |
| out_src | output | 32 | Updated source address |
| out_dst | output | 32 | Updated destination address |
| out_link | output | 32 | Updated link pointer |
| out_ctrl | output | 32 | Updated control word |
| out_en | output | 1 | Updated channel enable |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Lane-positioned write data |
| mem_req_be | output | 4 | Byte-lane enables for writes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data word |

## Verification
Most internal faults appear at the ports within a single unit. A wrong gather offset or lane choice puts incorrect bytes into destination memory at the next write. A wrong step size or a missed increment shows up in `out_src` or `out_dst` when `done` pulses. A count or chain error appears in `out_ctrl`, `out_link`, `out_en` or `tc_evt` in that same `done` cycle. Descriptor ordering faults are visible in the read addresses issued in the last four requests before `done`. Handshake faults are caught at the first stalled cycle, through request fields that change or a request issued while a read is still outstanding.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int CTL_CNT_W   = 12;
  localparam int CTL_CODE_W  = 3;
  localparam int CTL_SW_LSB  = 18;
  localparam int CTL_DW_LSB  = 21;
  localparam int CTL_SRC_INC = 26;
  localparam int CTL_DST_INC = 27;
  localparam int CTL_TC_REQ  = 31;
  localparam int LINK_IDX_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_LL_REQ,
    ST_LL_WAIT,
    ST_FIN
  } xfer_state_e;

  // Descriptor fetch order: source, destination, control, then link last.
  function automatic logic [3:0] link_field_ofs(input logic [LINK_IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 4'd0;
      2'd1:    return 4'd4;
      2'd2:    return 4'd12;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/xfer_width_calc.sv
module xfer_width_calc #(
  parameter int LANE_W = 2,
  parameter int CODE_W = 3,
  localparam int LOG_W = $clog2(LANE_W + 1),
  localparam int NCNT_W = LANE_W + 1
) (
  input  logic [CODE_W-1:0] sw_code,
  input  logic [CODE_W-1:0] dw_code,
  output logic [LOG_W-1:0]  sw_log,
  output logic [LOG_W-1:0]  dw_log,
  output logic [NCNT_W-1:0] n_rd,
  output logic [NCNT_W-1:0] n_wr
);
  logic [CODE_W-1:0] sw_sat, dw_sat;

  always_comb begin
    sw_sat = (sw_code > CODE_W'(LANE_W)) ? CODE_W'(LANE_W) : sw_code;
    dw_sat = (dw_code > CODE_W'(LANE_W)) ? CODE_W'(LANE_W) : dw_code;
    sw_log = sw_sat[LOG_W-1:0];
    dw_log = dw_sat[LOG_W-1:0];
    n_rd = (dw_log > sw_log) ? (NCNT_W'(1) << (dw_log - sw_log)) : NCNT_W'(1);
    n_wr = (sw_log > dw_log) ? (NCNT_W'(1) << (sw_log - dw_log)) : NCNT_W'(1);
  end
endmodule

// File: rtl/xfer_lane_align.sv
module xfer_lane_align #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int LOG_W = $clog2(LANE_W + 1)
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [DATA_W-1:0] rd_item,
  input  logic [DATA_W-1:0] wr_item,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [LOG_W-1:0]  wr_log,
  output logic [DATA_W-1:0] wr_word,
  output logic [LANES-1:0]  wr_be
);
  assign rd_item = rd_word >> {rd_lane, 3'b000};
  assign wr_word = wr_item << {wr_lane, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_be
    assign wr_be[g] = (g >= int'(wr_lane)) && (g < int'(wr_lane) + (1 << wr_log));
  end
endmodule

// File: rtl/xfer_pack_buf.sv
module xfer_pack_buf #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int LOG_W = $clog2(LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LANE_W-1:0] load_ofs,
  input  logic [LOG_W-1:0]  load_log,
  input  logic [DATA_W-1:0] load_data,
  input  logic [LANE_W-1:0] take_ofs,
  output logic [DATA_W-1:0] take_data
);
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] flat;

  assign placed = load_data << {load_ofs, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    assign hit = load_en && (g >= int'(load_ofs)) && (g < int'(load_ofs) + (1 << load_log));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= placed[8*g +: 8];
    end
    assign flat[8*g +: 8] = byte_q;
  end

  assign take_data = flat >> {take_ofs, 3'b000};
endmodule

// File: rtl/xfer_unit_engine.sv
module xfer_unit_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  input  logic [ADDR_W-1:0] in_link,
  input  logic [DATA_W-1:0] in_ctrl,
  input  logic              in_en,
  output logic              busy,
  output logic              done,
  output logic              tc_evt,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic [ADDR_W-1:0] out_link,
  output logic [DATA_W-1:0] out_ctrl,
  output logic              out_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int LOG_W  = $clog2(LANE_W + 1);
  localparam int NCNT_W = LANE_W + 1;

  xfer_state_e           state_q;
  logic [ADDR_W-1:0]     src_q, dst_q, lnk_q;
  logic [DATA_W-1:0]     ctl_q;
  logic                  en_q, tc_q;
  logic [LANE_W-1:0]     rd_idx, wr_idx;
  logic [LINK_IDX_W-1:0] ll_idx;

  logic [LOG_W-1:0]      sw_log, dw_log;
  logic [NCNT_W-1:0]     n_rd, n_wr;
  logic                  rd_last, wr_last;
  logic [ADDR_W-1:0]     sw_bytes, dw_bytes;
  logic [CTL_CNT_W-1:0]  cnt_next;
  logic [DATA_W-1:0]     rd_item, buf_out, wr_word;
  logic [LANES-1:0]      wr_be;
  logic [LANE_W-1:0]     rd_ofs, wr_ofs;
  logic                  buf_load;

  xfer_width_calc #(.LANE_W(LANE_W), .CODE_W(CTL_CODE_W)) u_width (
    .sw_code (ctl_q[CTL_SW_LSB +: CTL_CODE_W]),
    .dw_code (ctl_q[CTL_DW_LSB +: CTL_CODE_W]),
    .sw_log  (sw_log),
    .dw_log  (dw_log),
    .n_rd    (n_rd),
    .n_wr    (n_wr)
  );

  assign rd_ofs   = rd_idx << sw_log;
  assign wr_ofs   = wr_idx << dw_log;
  assign buf_load = (state_q == ST_RD_WAIT) && mem_rsp_valid;

  xfer_pack_buf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (buf_load),
    .load_ofs  (rd_ofs),
    .load_log  (sw_log),
    .load_data (rd_item),
    .take_ofs  (wr_ofs),
    .take_data (buf_out)
  );

  xfer_lane_align #(.DATA_W(DATA_W)) u_lane (
    .rd_word (mem_rsp_rdata),
    .rd_lane (src_q[LANE_W-1:0]),
    .rd_item (rd_item),
    .wr_item (buf_out),
    .wr_lane (dst_q[LANE_W-1:0]),
    .wr_log  (dw_log),
    .wr_word (wr_word),
    .wr_be   (wr_be)
  );

  assign rd_last  = ({1'b0, rd_idx} == n_rd - NCNT_W'(1));
  assign wr_last  = ({1'b0, wr_idx} == n_wr - NCNT_W'(1));
  assign sw_bytes = ADDR_W'(1) << sw_log;
  assign dw_bytes = ADDR_W'(1) << dw_log;
  assign cnt_next = ctl_q[CTL_CNT_W-1:0] - CTL_CNT_W'(1);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    mem_req_be    = '0;
    case (state_q)
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q;
      end
      ST_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = dst_q;
        mem_req_wdata = wr_word;
        mem_req_be    = wr_be;
      end
      ST_LL_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = lnk_q + ADDR_W'(link_field_ofs(ll_idx));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      lnk_q   <= '0;
      ctl_q   <= '0;
      en_q    <= 1'b0;
      tc_q    <= 1'b0;
      rd_idx  <= '0;
      wr_idx  <= '0;
      ll_idx  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          src_q  <= in_src;
          dst_q  <= in_dst;
          lnk_q  <= in_link;
          ctl_q  <= in_ctrl;
          en_q   <= in_en;
          tc_q   <= 1'b0;
          rd_idx <= '0;
          wr_idx <= '0;
          ll_idx <= '0;
          state_q <= (in_ctrl[CTL_CNT_W-1:0] == '0) ? ST_FIN : ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (ctl_q[CTL_SRC_INC]) src_q <= src_q + sw_bytes;
          if (rd_last) state_q <= ST_WR_REQ;
          else begin
            rd_idx  <= rd_idx + LANE_W'(1);
            state_q <= ST_RD_REQ;
          end
        end
        ST_WR_REQ: if (mem_req_ready) begin
          if (ctl_q[CTL_DST_INC]) dst_q <= dst_q + dw_bytes;
          if (wr_last) begin
            ctl_q[CTL_CNT_W-1:0] <= cnt_next;
            if (cnt_next == '0) begin
              tc_q <= ctl_q[CTL_TC_REQ];
              if (lnk_q != '0) state_q <= ST_LL_REQ;
              else begin
                en_q    <= 1'b0;
                state_q <= ST_FIN;
              end
            end else begin
              state_q <= ST_FIN;
            end
          end else begin
            wr_idx <= wr_idx + LANE_W'(1);
          end
        end
        ST_LL_REQ: if (mem_req_ready) state_q <= ST_LL_WAIT;
        ST_LL_WAIT: if (mem_rsp_valid) begin
          case (ll_idx)
            2'd0:    src_q <= ADDR_W'(mem_rsp_rdata);
            2'd1:    dst_q <= ADDR_W'(mem_rsp_rdata);
            2'd2:    ctl_q <= mem_rsp_rdata;
            default: lnk_q <= ADDR_W'(mem_rsp_rdata);
          endcase
          if (ll_idx == LINK_IDX_W'(3)) state_q <= ST_FIN;
          else begin
            ll_idx  <= ll_idx + LINK_IDX_W'(1);
            state_q <= ST_LL_REQ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign tc_evt   = done && tc_q;
  assign out_src  = src_q;
  assign out_dst  = dst_q;
  assign out_link = lnk_q;
  assign out_ctrl = ctl_q;
  assign out_en   = en_q;
endmodule

// File: rtl/xfer_unit_engine_chk.sv
module xfer_unit_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tc_evt,
  input logic              out_en,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [DATA_W/8-1:0] mem_req_be,
  input logic              mem_rsp_valid
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_pend <= 1'b1;
    else if (mem_rsp_valid) rd_pend <= 1'b0;
  end

  a_r1_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata) && $stable(mem_req_be));

  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r9_tc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |-> done);

  a_r8_enable_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !$rose(out_en));

  a_r11_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_be != '0);
endmodule

bind xfer_unit_engine xfer_unit_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .tc_evt        (tc_evt),
  .out_en        (out_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_be    (mem_req_be),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sim_xfer_unit_engine.sv
module sim_xfer_unit_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] in_src, in_dst, in_link, in_ctrl;
  logic        in_en;
  logic        busy, done, tc_evt, out_en;
  logic [31:0] out_src, out_dst, out_link, out_ctrl;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  xfer_unit_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_src(in_src), .in_dst(in_dst), .in_link(in_link), .in_ctrl(in_ctrl), .in_en(in_en),
    .busy(busy), .done(done), .tc_evt(tc_evt),
    .out_src(out_src), .out_dst(out_dst), .out_link(out_link), .out_ctrl(out_ctrl), .out_en(out_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  logic [7:0]  mem     [0:1023];
  logic [7:0]  exp_mem [0:1023];
  logic [31:0] rd_log  [0:255];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic        pend;
  logic [31:0] pend_data;
  logic [7:0]  lfsr;
  logic [9:0]  base;

  // Memory model: decides acceptance at the falling edge, answers reads one cycle later.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    pend = 1'b0;
    pend_data = '0;
    lfsr = 8'h5A;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = pend_data;
        pend = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[2];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        base = mem_req_addr[9:0] & 10'h3FC;
        if (mem_req_we) begin
          for (int i = 0; i < 4; i++)
            if (mem_req_be[i]) mem[base + 10'(i)] = mem_req_wdata[8*i +: 8];
          wr_cnt++;
        end else begin
          pend = 1'b1;
          pend_data = {mem[base + 10'd3], mem[base + 10'd2], mem[base + 10'd1], mem[base]};
          rd_log[rd_cnt % 256] = mem_req_addr;
          rd_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lg(input logic [2:0] code);
    return (code > 3'd2) ? 2 : int'(code);
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [2:0] sw, input logic [2:0] dw,
                                          input logic si, input logic di, input logic [11:0] cnt);
    return {4'b0000, di, si, 2'b01, dw, sw, 6'h2A, cnt};
  endfunction

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[a + i] = w[8*i +: 8];
  endtask

  int  run_cyc;
  bit  run_tc;

  task automatic run_unit(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                          input logic [31:0] c, input logic e, input bit extra_start);
    @(negedge clk);
    in_src = s; in_dst = d; in_link = l; in_ctrl = c; in_en = e; start = 1'b1;
    @(negedge clk);
    if (extra_start) begin
      in_src = 32'h0000_01F0;
      in_dst = 32'h0000_03F0;
      @(negedge clk);
    end
    start = 1'b0;
    run_cyc = 1;
    while (!done && run_cyc < 5000) begin
      @(negedge clk);
      run_cyc++;
    end
    if (!done) chk("R10 done never seen", 32'd0, 32'd1);
    run_tc = tc_evt;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  sw;
    logic [2:0]  dw;
    logic        si;
    logic        di;
    logic [9:0]  src;
    logic [9:0]  dst;
    logic [11:0] cnt;
    logic [9:0]  es;
    logic [9:0]  ed;
    logic [2:0]  nwr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 3'd2, 1'b1, 1'b1, 10'h100, 10'h200, 12'd5, 10'h104, 10'h204, 3'd1},
    '{3'd0, 3'd2, 1'b1, 1'b1, 10'h101, 10'h210, 12'd3, 10'h105, 10'h214, 3'd1},
    '{3'd2, 3'd0, 1'b1, 1'b1, 10'h120, 10'h223, 12'd2, 10'h124, 10'h227, 3'd4},
    '{3'd1, 3'd2, 1'b0, 1'b1, 10'h132, 10'h230, 12'd4, 10'h132, 10'h234, 3'd1},
    '{3'd1, 3'd0, 1'b1, 1'b0, 10'h140, 10'h240, 12'd6, 10'h142, 10'h240, 3'd2},
    '{3'd3, 3'd7, 1'b1, 1'b1, 10'h150, 10'h250, 12'd9, 10'h154, 10'h254, 3'd1},
    '{3'd0, 3'd1, 1'b1, 1'b1, 10'h163, 10'h262, 12'd7, 10'h165, 10'h264, 3'd1}
  };

  task automatic apply_model(input vec_t v, output int nrd);
    logic [7:0] gbuf [0:3];
    int sl, dl, sb, db, nw;
    sl = lg(v.sw); dl = lg(v.dw);
    sb = 1 << sl; db = 1 << dl;
    nrd = (dl > sl) ? (1 << (dl - sl)) : 1;
    nw  = (sl > dl) ? (1 << (sl - dl)) : 1;
    for (int r = 0; r < nrd; r++)
      for (int b = 0; b < sb; b++)
        gbuf[r*sb + b] = exp_mem[int'(v.src) + (v.si ? r*sb : 0) + b];
    for (int w = 0; w < nw; w++)
      for (int b = 0; b < db; b++)
        exp_mem[int'(v.dst) + (v.di ? w*db : 0) + b] = gbuf[w*db + b];
  endtask

  initial begin
    int nrd, rc0, wc0, mism;
    logic [31:0] c;
    rst_n = 1'b0; start = 1'b0;
    in_src = '0; in_dst = '0; in_link = '0; in_ctrl = '0; in_en = 1'b0;
    for (int a = 0; a < 1024; a++) begin
      mem[a] = (a < 512) ? 8'((a * 13 + 5) & 255) : 8'h00;
      exp_mem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R10 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R10 reset out_src", out_src, 32'd0);
    chk("R10 reset out_ctrl", out_ctrl, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      c = mk_ctrl(v.sw, v.dw, v.si, v.di, v.cnt);
      apply_model(v, nrd);
      rc0 = rd_cnt; wc0 = wr_cnt;
      run_unit({22'd0, v.src}, {22'd0, v.dst}, 32'd0, c, 1'b1, 1'b0);
      chk($sformatf("R4 src end vec%0d", i), out_src, {22'd0, v.es});
      chk($sformatf("R4 dst end vec%0d", i), out_dst, {22'd0, v.ed});
      chk($sformatf("R5 ctrl vec%0d", i), out_ctrl, {c[31:12], v.cnt - 12'd1});
      chk($sformatf("R3 writes vec%0d", i), 32'(wr_cnt - wc0), {29'd0, v.nwr});
      chk($sformatf("R1 R2 reads vec%0d", i), 32'(rd_cnt - rc0), 32'(nrd));
      mism = 0;
      for (int a = 512; a < 768; a++) if (mem[a] !== exp_mem[a]) mism++;
      chk($sformatf("R11 R3 dest bytes vec%0d", i), 32'(mism), 32'd0);
      chk($sformatf("R9 no tc vec%0d", i), 32'(run_tc), 32'd0);
    end

    // R6: zero count
    rc0 = rd_cnt; wc0 = wr_cnt;
    c = 32'h8C48_0000;
    run_unit(32'h111, 32'h222, 32'h0, c, 1'b1, 1'b0);
    chk("R6 done next cycle", 32'(run_cyc), 32'd1);
    chk("R6 no accesses", 32'((rd_cnt - rc0) + (wr_cnt - wc0)), 32'd0);
    chk("R6 ctrl unchanged", out_ctrl, c);
    chk("R6 src unchanged", out_src, 32'h111);
    chk("R6 no tc", 32'(run_tc), 32'd0);

    // R8 R9: terminal, no link, event requested
    run_unit(32'h190, 32'h290, 32'h0, 32'h8C48_0001, 1'b1, 1'b0);
    chk("R8 enable cleared", 32'(out_en), 32'd0);
    chk("R9 tc raised", 32'(run_tc), 32'd1);
    chk("R5 count zero", out_ctrl, 32'h8C48_0000);
    chk("R10 done low after pulse", 32'(done), 32'd0);
    chk("R10 idle after unit", 32'(busy), 32'd0);

    // R9: terminal without event request
    run_unit(32'h194, 32'h294, 32'h0, 32'h0C48_0001, 1'b1, 1'b0);
    chk("R9 tc absent", 32'(run_tc), 32'd0);
    chk("R8 enable cleared 2", 32'(out_en), 32'd0);

    // R7: descriptor reload
    put_word(32'h300, 32'h0000_0180);
    put_word(32'h304, 32'h0000_0280);
    put_word(32'h308, 32'h0000_0310);
    put_word(32'h30C, 32'h0C48_0007);
    run_unit(32'h170, 32'h270, 32'h300, 32'h8C48_0001, 1'b1, 1'b0);
    chk("R7 src loaded", out_src, 32'h180);
    chk("R7 dst loaded", out_dst, 32'h280);
    chk("R7 ctrl loaded", out_ctrl, 32'h0C48_0007);
    chk("R7 link loaded", out_link, 32'h310);
    chk("R7 enable kept", 32'(out_en), 32'd1);
    chk("R7 order word0", rd_log[(rd_cnt - 4) % 256], 32'h300);
    chk("R7 order word1", rd_log[(rd_cnt - 3) % 256], 32'h304);
    chk("R7 order word2", rd_log[(rd_cnt - 2) % 256], 32'h30C);
    chk("R7 order word3", rd_log[(rd_cnt - 1) % 256], 32'h308);
    chk("R9 tc from finished word", 32'(run_tc), 32'd1);

    // R10: start held while busy is ignored
    run_unit(32'h100, 32'h2C0, 32'h0, 32'h0C6A_F005, 1'b1, 1'b1);
    chk("R10 start ignored src", out_src, 32'h104);
    chk("R10 start ignored dst", out_dst, 32'h2C4);
    chk("R10 busy cleared", 32'(busy), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule